// File: doc/BRIEF.md
# Load/Store Bus Watchpoint Generator

This block watches every data-bus (load or store) cycle and raises trap requests when a programmed watchpoint condition is met. Two external address comparators and two external data comparators report a hit flag each per cycle. For each of `NUM_WP` watchpoints, a control field picks how the two address flags are combined and how the two data flags are combined: the first flag alone, the second alone, both, or either. A per-side care bit can turn that side into "always matches". A 2-bit access-type field forms the third condition, and all three conditions must hold in the same bus cycle.

A qualifying event is gated by the recoverable-interrupt status bit unless a non-mask bit is set. It is then routed to a software-trap output and a debug-port-trap output, each through its own enable. The software enables, the match fields and the non-mask bit sit in one control word that ordinary software writes. The debug-port-trap enables can be loaded only through a separate debug-side write port. Both trap outputs are registered.

Top module: `lsbus_watchpoint`

## Requirements
- R1: Address-side select code (field bits [1:0]) with address care set: 00 gives address hit 0 alone, 01 gives hit 1 alone, 10 gives hit 0 AND hit 1, 11 gives hit 0 OR hit 1.
- R2: Data-side select code (field bits [4:3]) with data care set: 00 gives data hit 0 alone, 01 gives hit 1 alone, 10 gives AND, 11 gives OR.
- R3: When a side's care bit is 0 (address care is field bit 2, data care is field bit 5), that side matches whatever its hit flags are.
- R4: Access-type field bits [7:6] encode 00 as never, 01 as read only (`bus_write`=0), 10 as write only, and 11 as either. A watchpoint fires only when the address side, the data side and the access type all match in the same cycle.
- R5: No event is produced when `bus_valid` is 0 or `bus_fetch` is 1.
- R6: With the non-mask bit at 0, an event is recognised only when `ri_status` is 1. With the non-mask bit at 1, it is recognised regardless of `ri_status`. This applies to both outputs.
- R7: `sw_trap[i]` requires software enable i. `dbg_trap[i]` requires debug enable i. The two enables are independent.
- R8: The control word layout is as follows: field i is at [8i+7:8i], software enable i is at [8*NUM_WP+i], and the non-mask bit is at [9*NUM_WP]. A write through `cfg_we` never changes the debug enables. `dbg_we` loads the debug enables from `dbg_wdata`.
- R9: Reset clears the control word, the debug enables and both trap outputs.
- R10: A trap output goes high in the cycle after the qualifying bus cycle and stays high for exactly one clock unless the next cycle also qualifies. A control write takes effect for bus cycles presented after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus cycle valid this clock |
| bus_fetch | input | 1 | Cycle is an instruction fetch |
| bus_write | input | 1 | 1 = store, 0 = load |
| ri_status | input | 1 | Recoverable-interrupt status bit |
| addr_hit | input | 2 | Address comparator hit flags |
| data_hit | input | 2 | Data comparator hit flags |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 9*NUM_WP+1 | Control word write data |
| dbg_we | input | 1 | Debug enable write strobe |
| dbg_wdata | input | NUM_WP | Debug enable write data |
| sw_trap | output | NUM_WP | Registered software-trap requests |
| dbg_trap | output | NUM_WP | Registered debug-port-trap requests |

## Verification
A bus cycle presented before rising edge k produces its trap outputs just after edge k. The bench drives every input on a falling edge and reads the outputs on the falling edge that follows the next rising edge. A control or debug write is applied on one rising edge, and the first bus cycle checked against it is presented on the falling edge after that write. The one-clock pulse width is checked by dropping `bus_valid` and reading the outputs low one clock later. Expected values come from a bench model written from the field encodings above.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

  typedef enum logic [1:0] {
    PAIR_FIRST  = 2'b00,
    PAIR_SECOND = 2'b01,
    PAIR_BOTH   = 2'b10,
    PAIR_EITHER = 2'b11
  } pair_sel_e;

  typedef enum logic [1:0] {
    ACC_NEVER = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_ANY   = 2'b11
  } acc_sel_e;

  // Packed MSB first: acc [7:6], data_care [5], data_sel [4:3],
  // addr_care [2], addr_sel [1:0]
  typedef struct packed {
    acc_sel_e  acc;
    logic      data_care;
    pair_sel_e data_sel;
    logic      addr_care;
    pair_sel_e addr_sel;
  } wp_field_t;

  localparam int FIELD_W = $bits(wp_field_t);

endpackage

// File: rtl/lsw_pair_match.sv
module lsw_pair_match
  import lsw_pkg::*;
(
  input  pair_sel_e  sel,
  input  logic       care,
  input  logic [1:0] hit,
  output logic       match
);

  logic combined;

  always_comb begin
    unique case (sel)
      PAIR_FIRST:  combined = hit[0];
      PAIR_SECOND: combined = hit[1];
      PAIR_BOTH:   combined = hit[0] & hit[1];
      default:     combined = hit[0] | hit[1];
    endcase
  end

  assign match = ~care | combined;

endmodule

// File: rtl/lsw_ctrl_regs.sv
module lsw_ctrl_regs
  import lsw_pkg::*;
#(
  parameter int NUM_WP = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_we,
  input  logic [9*NUM_WP:0]           cfg_wdata,
  input  logic                        dbg_we,
  input  logic [NUM_WP-1:0]           dbg_wdata,
  output wp_field_t [NUM_WP-1:0]      fields,
  output logic [NUM_WP-1:0]           sw_en,
  output logic [NUM_WP-1:0]           dbg_en,
  output logic                        nomask
);

  localparam int FIELDS_W = FIELD_W * NUM_WP;
  localparam int CFG_W    = FIELDS_W + NUM_WP + 1;

  logic [CFG_W-1:0]  cfg_q;
  logic [NUM_WP-1:0] dbg_en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_en_q <= '0;
    end else if (dbg_we) begin
      dbg_en_q <= dbg_wdata;
    end
  end

  assign fields = cfg_q[FIELDS_W-1:0];
  assign sw_en  = cfg_q[FIELDS_W +: NUM_WP];
  assign nomask = cfg_q[CFG_W-1];
  assign dbg_en = dbg_en_q;

  // R8: the software write port leaves the debug enables alone
  a_r8_dbg_readonly: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !dbg_we) |=> $stable(dbg_en_q));

  // R9: reset clears both registers
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (cfg_q == '0 && dbg_en_q == '0));

endmodule

// File: rtl/lsw_wp_lane.sv
module lsw_wp_lane
  import lsw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  wp_field_t  field,
  input  logic       sw_en,
  input  logic       dbg_en,
  input  logic       nomask,
  input  logic       bus_valid,
  input  logic       bus_fetch,
  input  logic       bus_write,
  input  logic       ri_status,
  input  logic [1:0] addr_hit,
  input  logic [1:0] data_hit,
  output logic       sw_trap_q,
  output logic       dbg_trap_q
);

  logic [1:0] side_match;
  logic       acc_ok;
  logic       recognised;
  logic       wp_event;

  // side 0 = address comparators, side 1 = data comparators
  for (genvar s = 0; s < 2; s++) begin : g_side
    lsw_pair_match u_pair (
      .sel   (s == 0 ? field.addr_sel  : field.data_sel),
      .care  (s == 0 ? field.addr_care : field.data_care),
      .hit   (s == 0 ? addr_hit        : data_hit),
      .match (side_match[s])
    );
  end

  always_comb begin
    unique case (field.acc)
      ACC_NEVER: acc_ok = 1'b0;
      ACC_READ:  acc_ok = ~bus_write;
      ACC_WRITE: acc_ok = bus_write;
      default:   acc_ok = 1'b1;
    endcase
  end

  assign recognised = nomask | ri_status;
  assign wp_event   = bus_valid & ~bus_fetch & acc_ok & (&side_match) & recognised;

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_trap_q  <= 1'b0;
      dbg_trap_q <= 1'b0;
    end else begin
      sw_trap_q  <= wp_event & sw_en;
      dbg_trap_q <= wp_event & dbg_en;
    end
  end

  // R5: a trap always follows a valid data-bus cycle
  a_r5_needs_data_cycle: assert property (@(posedge clk) disable iff (rst)
    (sw_trap_q || dbg_trap_q) |-> $past(bus_valid && !bus_fetch));

  // R6: masked mode needs the recoverable-interrupt bit
  a_r6_mask_gate: assert property (@(posedge clk) disable iff (rst)
    (sw_trap_q || dbg_trap_q) |-> ($past(nomask) || $past(ri_status)));

  // R7: each output follows its own enable
  a_r7_sw_enable: assert property (@(posedge clk) disable iff (rst)
    sw_trap_q |-> $past(sw_en));

  a_r7_dbg_enable: assert property (@(posedge clk) disable iff (rst)
    dbg_trap_q |-> $past(dbg_en));

  // R4: access type never blocks all events
  a_r4_never_type: assert property (@(posedge clk) disable iff (rst)
    (sw_trap_q || dbg_trap_q) |-> ($past(field.acc) != ACC_NEVER));

endmodule

// File: rtl/lsbus_watchpoint.sv
module lsbus_watchpoint
  import lsw_pkg::*;
#(
  parameter int NUM_WP = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_valid,
  input  logic                bus_fetch,
  input  logic                bus_write,
  input  logic                ri_status,
  input  logic [1:0]          addr_hit,
  input  logic [1:0]          data_hit,
  input  logic                cfg_we,
  input  logic [9*NUM_WP:0]   cfg_wdata,
  input  logic                dbg_we,
  input  logic [NUM_WP-1:0]   dbg_wdata,
  output logic [NUM_WP-1:0]   sw_trap,
  output logic [NUM_WP-1:0]   dbg_trap
);

  wp_field_t [NUM_WP-1:0] fields;
  logic [NUM_WP-1:0]      sw_en;
  logic [NUM_WP-1:0]      dbg_en;
  logic                   nomask;

  lsw_ctrl_regs #(.NUM_WP(NUM_WP)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .dbg_we    (dbg_we),
    .dbg_wdata (dbg_wdata),
    .fields    (fields),
    .sw_en     (sw_en),
    .dbg_en    (dbg_en),
    .nomask    (nomask)
  );

  for (genvar i = 0; i < NUM_WP; i++) begin : g_lane
    lsw_wp_lane u_lane (
      .clk        (clk),
      .rst        (rst),
      .field      (fields[i]),
      .sw_en      (sw_en[i]),
      .dbg_en     (dbg_en[i]),
      .nomask     (nomask),
      .bus_valid  (bus_valid),
      .bus_fetch  (bus_fetch),
      .bus_write  (bus_write),
      .ri_status  (ri_status),
      .addr_hit   (addr_hit),
      .data_hit   (data_hit),
      .sw_trap_q  (sw_trap[i]),
      .dbg_trap_q (dbg_trap[i])
    );
  end

  // R10: an idle bus leaves the outputs low one clock later
  a_r10_idle_clears: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> (sw_trap == '0 && dbg_trap == '0));

endmodule

// File: tb/lsbus_watchpoint_tb.sv
module lsbus_watchpoint_tb;

  localparam int N  = 2;
  localparam int CW = 9*N+1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_fetch = 1'b0, bus_write = 1'b0, ri_status = 1'b0;
  logic [1:0] addr_hit = '0, data_hit = '0;
  logic cfg_we = 1'b0;
  logic [CW-1:0] cfg_wdata = '0;
  logic dbg_we = 1'b0;
  logic [N-1:0] dbg_wdata = '0;
  logic [N-1:0] sw_trap, dbg_trap;

  logic [CW-1:0] cfg_sh = '0;
  logic [N-1:0]  dbg_sh = '0;
  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #5 clk = ~clk;

  lsbus_watchpoint #(.NUM_WP(N)) u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_fetch(bus_fetch),
    .bus_write(bus_write), .ri_status(ri_status), .addr_hit(addr_hit),
    .data_hit(data_hit), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .dbg_we(dbg_we), .dbg_wdata(dbg_wdata), .sw_trap(sw_trap), .dbg_trap(dbg_trap)
  );

  function automatic logic pair_ok(logic [1:0] sel, logic care, logic [1:0] h);
    if (!care) return 1'b1;
    case (sel)
      2'd0: return h[0];
      2'd1: return h[1];
      2'd2: return h[0] & h[1];
      default: return h[0] | h[1];
    endcase
  endfunction

  function automatic logic [N-1:0] model_event();
    logic [N-1:0] ev;
    for (int i = 0; i < N; i++) begin
      logic [7:0] f;
      logic acc;
      f = cfg_sh[8*i +: 8];
      acc = (f[7:6] == 2'b11) || (f[7:6] == 2'b01 && !bus_write) ||
            (f[7:6] == 2'b10 && bus_write);
      ev[i] = bus_valid && !bus_fetch && acc &&
              pair_ok(f[1:0], f[2], addr_hit) && pair_ok(f[4:3], f[5], data_hit) &&
              (cfg_sh[9*N] || ri_status);
    end
    return ev;
  endfunction

  task automatic check(string req, logic [N-1:0] exp_sw, logic [N-1:0] exp_dbg);
    n_tests++;
    if (sw_trap !== exp_sw || dbg_trap !== exp_dbg) begin
      n_fail++;
      $display("FAIL %s: sw=%b dbg=%b expected sw=%b dbg=%b", req, sw_trap, dbg_trap, exp_sw, exp_dbg);
    end
  endtask

  task automatic write_cfg(logic [CW-1:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_sh = v;
  endtask

  task automatic write_dbg(logic [N-1:0] v);
    @(negedge clk);
    dbg_we = 1'b1; dbg_wdata = v;
    @(posedge clk);
    @(negedge clk);
    dbg_we = 1'b0;
    dbg_sh = v;
  endtask

  // inputs are set at a falling edge; result is read one full clock later
  task automatic bus_cycle(string req, logic v, logic f, logic w, logic ri,
                           logic [1:0] ah, logic [1:0] dh);
    logic [N-1:0] ev;
    bus_valid = v; bus_fetch = f; bus_write = w; ri_status = ri;
    addr_hit = ah; data_hit = dh;
    ev = model_event();
    @(posedge clk);
    @(negedge clk);
    check(req, ev & cfg_sh[8*N +: N], ev & dbg_sh);
    bus_valid = 1'b0;
  endtask

  function automatic logic [7:0] fld(logic [1:0] acc, logic dc, logic [1:0] ds,
                                     logic ac, logic [1:0] as_);
    return {acc, dc, ds, ac, as_};
  endfunction

  function automatic logic [CW-1:0] word(logic nm, logic [N-1:0] swe,
                                         logic [7:0] f1, logic [7:0] f0);
    return {nm, swe, f1, f0};
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check("R9 reset outputs", '0, '0);
  endtask

  task automatic t_addr_select();
    for (int s = 0; s < 4; s++) begin
      write_cfg(word(1'b0, 2'b11, fld(2'b11, 1'b0, 2'd0, 1'b0, 2'd0),
                     fld(2'b11, 1'b0, 2'd0, 1'b1, 2'(s))));
      for (int h = 0; h < 4; h++)
        bus_cycle("R1 addr select", 1'b1, 1'b0, 1'b0, 1'b1, 2'(h), 2'(3-h));
    end
  endtask

  task automatic t_data_select();
    for (int s = 0; s < 4; s++) begin
      write_cfg(word(1'b0, 2'b11, fld(2'b11, 1'b1, 2'(3-s), 1'b0, 2'd0),
                     fld(2'b11, 1'b1, 2'(s), 1'b0, 2'd0)));
      for (int h = 0; h < 4; h++)
        bus_cycle("R2 data select", 1'b1, 1'b0, 1'b1, 1'b1, 2'(3-h), 2'(h));
    end
  endtask

  task automatic t_care();
    write_cfg(word(1'b0, 2'b11, fld(2'b11, 1'b1, 2'd2, 1'b1, 2'd2),
                   fld(2'b11, 1'b0, 2'd2, 1'b0, 2'd2)));
    bus_cycle("R3 dont care no hits", 1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 2'b00);
    bus_cycle("R3 care all hits", 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11);
    bus_cycle("R3 care one side missing", 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 2'b01);
  endtask

  task automatic t_access();
    for (int a = 0; a < 4; a++) begin
      write_cfg(word(1'b0, 2'b11, fld(2'(3-a), 1'b0, 2'd0, 1'b0, 2'd0),
                     fld(2'(a), 1'b0, 2'd0, 1'b0, 2'd0)));
      bus_cycle("R4 access read", 1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 2'b00);
      bus_cycle("R4 access write", 1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 2'b00);
    end
  endtask

  task automatic t_qualifiers();
    write_cfg(word(1'b0, 2'b11, fld(2'b11, 1'b0, 2'd0, 1'b0, 2'd0),
                   fld(2'b11, 1'b0, 2'd0, 1'b0, 2'd0)));
    bus_cycle("R5 valid low", 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11);
    bus_cycle("R5 fetch cycle", 1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 2'b11);
    bus_cycle("R5 data cycle", 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11);
  endtask

  task automatic t_nomask();
    write_dbg(2'b11);
    write_cfg(word(1'b0, 2'b11, fld(2'b11, 1'b0, 2'd0, 1'b0, 2'd0),
                   fld(2'b11, 1'b0, 2'd0, 1'b0, 2'd0)));
    bus_cycle("R6 masked ri=0", 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
    bus_cycle("R6 masked ri=1", 1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 2'b00);
    write_cfg(word(1'b1, 2'b11, fld(2'b11, 1'b0, 2'd0, 1'b0, 2'd0),
                   fld(2'b11, 1'b0, 2'd0, 1'b0, 2'd0)));
    bus_cycle("R6 nonmask ri=0", 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
    write_dbg(2'b00);
  endtask

  task automatic t_enables();
    write_cfg(word(1'b1, 2'b10, fld(2'b11, 1'b0, 2'd0, 1'b0, 2'd0),
                   fld(2'b11, 1'b0, 2'd0, 1'b0, 2'd0)));
    bus_cycle("R7 sw enable 1 only", 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
    write_dbg(2'b01);
    bus_cycle("R7 dbg enable 0 only", 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
    write_dbg(2'b00);
  endtask

  task automatic t_dbg_readonly();
    write_cfg('1);
    bus_cycle("R8 cfg write leaves dbg off", 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11);
    write_dbg(2'b10);
    write_cfg('1);
    bus_cycle("R8 cfg write keeps dbg=10", 1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 2'b11);
  endtask

  task automatic t_pulse();
    write_cfg(word(1'b1, 2'b11, fld(2'b11, 1'b0, 2'd0, 1'b0, 2'd0),
                   fld(2'b11, 1'b0, 2'd0, 1'b0, 2'd0)));
    bus_cycle("R10 pulse high", 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
    @(posedge clk);
    @(negedge clk);
    check("R10 pulse one clock", '0, '0);
    bus_cycle("R10 back to back a", 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
    bus_cycle("R10 back to back b", 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00);
  endtask

  task automatic t_reset_again();
    write_dbg(2'b11);
    @(negedge clk);
    rst = 1'b1;
    bus_valid = 1'b1; bus_fetch = 1'b0; ri_status = 1'b1;
    addr_hit = 2'b11; data_hit = 2'b11;
    @(posedge clk);
    @(negedge clk);
    check("R9 outputs in reset", '0, '0);
    rst = 1'b0;
    cfg_sh = '0; dbg_sh = '0;
    bus_cycle("R9 config cleared", 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_addr_select();
    t_data_select();
    t_care();
    t_access();
    t_qualifiers();
    t_nomask();
    t_enables();
    t_dbg_readonly();
    t_pulse();
    t_reset_again();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule